// File: doc/BRIEF.md
# Camera Receiver Control and Interrupt Register Block

This block is the register front end of a camera serial receiver. Software reaches it through a simple 32-bit register port with separate write and read strobes; reads return data one cycle after the strobe. It holds the core enable and a soft-reset request, reports live datapath conditions in a status word, and collects single-cycle event pulses from the datapath into write-one-to-clear interrupt status registers. A single registered, level-sensitive interrupt line is raised from that status, gated by a per-source enable register and a global enable.

Errors from extended virtual channels 4 to 15 land in their own write-one-to-clear register. Their OR appears as a summary bit in the main status word. That summary bit has no enable of its own and can only be cleared through the extended register. A soft reset is a handshake. Setting the request bit starts a bounded busy period that software can see in the status word. During that period all interrupt status is wiped and incoming events are dropped. The enable registers survive it.

Top module: `csi_rx_ctrl_regs`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: Offset 0x00 holds the core enable in bit 0 and the soft-reset request in bit 1; both read back as written.
- R3: A 0-to-1 change of the request bit starts a busy period, shown on bit 0 of offset 0x10, that lasts fewer than 100 cycles; busy does not return while the request stays set; the busy period zeroes offsets 0x24 and 0x34 but keeps offsets 0x20 and 0x28.
- R4: Offset 0x10 shows line-buffer full on bit 1, short-packet FIFO not empty on bit 2, short-packet FIFO full on bit 3 and the packet count on bits 31:16.
- R5: An event pulse on an input bit sets the same bit at offset 0x24 when that bit is in the stored set 0x807E3FFF, the core enable is 1 and no soft reset is busy. Pulses on any other bit, or pulses that arrive while the core is disabled, change nothing.
- R6: Writing 1 to an offset 0x24 bit clears it, writing 0 leaves it; an event arriving in the same cycle as a clear of its bit leaves the bit set.
- R7: Offset 0x28 stores the enable bits under mask 0x807E3FFF, so bit 30 reads 0; offset 0x20 bit 0 is the global enable.
- R8: One cycle after the state changes, the interrupt output equals global enable AND (any bit of status AND enable, OR summary bit 30).
- R9: Offset 0x34 holds 24 write-one-to-clear bits, set by the extended-channel event pulses under the same gating as R5; bit 30 of offset 0x24 reads as their OR.
- R10: Reads of unmapped offsets return 0; writes to offset 0x10, to unmapped offsets and to bit 30 of offset 0x24 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write byte offset |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | ADDR_W | Read byte offset |
| reg_rd_data | output | 32 | Read data, valid the cycle after the strobe |
| evt_core | input | 32 | Event pulses, one per status bit position |
| evt_ext | input | 2*NUM_EXT_VC | Extended-channel error pulses |
| lbuf_full_i | input | 1 | Line buffer full level |
| spkt_ne_i | input | 1 | Short-packet FIFO not empty level |
| spkt_full_i | input | 1 | Short-packet FIFO full level |
| pkt_count_i | input | PKT_W | Packet count |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with RESET_CYCLES at 12, NUM_EXT_VC at 12 and PKT_W at 16. The full 24-bit extended register and the full 16-bit packet-count field are therefore both exercised, and a complete soft-reset handshake fits inside a short polling loop. The short busy period lets the bench poll it, check it against the 100-cycle limit, and then see that the enables survive the wipe. Same-cycle set and clear collisions, the summary bit that has no enable, and writes to read-only fields are all driven directly.

// File: rtl/csirx_reg_pkg.sv
package csirx_reg_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_GIE  = 8'h20;
  localparam logic [7:0] OFS_ISR  = 8'h24;
  localparam logic [7:0] OFS_IER  = 8'h28;
  localparam logic [7:0] OFS_EXT  = 8'h34;

  localparam int          SUMMARY_BIT = 30;
  // bits backed by flops in the status and enable registers
  localparam logic [31:0] STORE_MASK  = 32'h807E_3FFF;

  function automatic logic [31:0] w1c_next(input logic [31:0] cur,
                                           input logic [31:0] set_bits,
                                           input logic [31:0] clr_bits);
    return (cur & ~clr_bits) | set_bits;
  endfunction
endpackage

// File: rtl/csirx_w1c_bank.sv
module csirx_w1c_bank #(
  parameter int          W    = 32,
  parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,
  input  logic         accept,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  import csirx_reg_pkg::*;

  logic [31:0] set_ext, clr_ext, cur_ext, nxt_ext;

  always_comb begin
    set_ext = accept ? 32'(evt) : 32'd0;
    clr_ext = clr_we ? 32'(clr_data) : 32'd0;
    cur_ext = 32'(q);
    nxt_ext = w1c_next(cur_ext, set_ext, clr_ext) & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) q <= '0;
    else             q <= nxt_ext[W-1:0];
  end
endmodule

// File: rtl/csirx_srst_seq.sv
module csirx_srst_seq #(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic busy
);
  localparam int CW = $clog2(RESET_CYCLES + 1);

  logic          req_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else begin
      req_d <= req;
      if (req && !req_d) begin
        busy <= 1'b1;
        cnt  <= CW'(RESET_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/csirx_irq_gen.sv
module csirx_irq_gen (
  input  logic        clk,
  input  logic        rst,
  input  logic        gie,
  input  logic [31:0] isr,
  input  logic [31:0] ier,
  input  logic        summary,
  output logic        irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gie & ((|(isr & ier)) | summary);
  end
endmodule

// File: rtl/csi_rx_ctrl_regs.sv
module csi_rx_ctrl_regs #(
  parameter int ADDR_W       = 8,
  parameter int NUM_EXT_VC   = 12,
  parameter int PKT_W        = 16,
  parameter int RESET_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr_en,
  input  logic [ADDR_W-1:0]       reg_wr_addr,
  input  logic [31:0]             reg_wr_data,
  input  logic                    reg_rd_en,
  input  logic [ADDR_W-1:0]       reg_rd_addr,
  output logic [31:0]             reg_rd_data,
  input  logic [31:0]             evt_core,
  input  logic [2*NUM_EXT_VC-1:0] evt_ext,
  input  logic                    lbuf_full_i,
  input  logic                    spkt_ne_i,
  input  logic                    spkt_full_i,
  input  logic [PKT_W-1:0]        pkt_count_i,
  output logic                    irq_o
);
  import csirx_reg_pkg::*;

  localparam int EXT_W = 2 * NUM_EXT_VC;

  logic             ctrl_en_q, ctrl_srst_q, gie_q;
  logic [31:0]      ier_q;
  logic [31:0]      isr_q;
  logic [EXT_W-1:0] ext_q;
  logic             busy;
  logic             accept;
  logic             summary;
  logic             wr_ctrl, wr_gie, wr_isr, wr_ier, wr_ext;
  logic [31:0]      isr_view, stat_word, rd_mux;

  assign wr_ctrl = reg_wr_en && (reg_wr_addr == ADDR_W'(OFS_CTRL));
  assign wr_gie  = reg_wr_en && (reg_wr_addr == ADDR_W'(OFS_GIE));
  assign wr_isr  = reg_wr_en && (reg_wr_addr == ADDR_W'(OFS_ISR));
  assign wr_ier  = reg_wr_en && (reg_wr_addr == ADDR_W'(OFS_IER));
  assign wr_ext  = reg_wr_en && (reg_wr_addr == ADDR_W'(OFS_EXT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q   <= 1'b0;
      ctrl_srst_q <= 1'b0;
      gie_q       <= 1'b0;
      ier_q       <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en_q   <= reg_wr_data[0];
        ctrl_srst_q <= reg_wr_data[1];
      end
      if (wr_gie) gie_q <= reg_wr_data[0];
      if (wr_ier) ier_q <= reg_wr_data & STORE_MASK;
    end
  end

  csirx_srst_seq #(.RESET_CYCLES(RESET_CYCLES)) u_srst (
    .clk (clk),
    .rst (rst),
    .req (ctrl_srst_q),
    .busy(busy)
  );

  assign accept = ctrl_en_q & ~busy;

  csirx_w1c_bank #(.W(32), .MASK(STORE_MASK)) u_isr (
    .clk     (clk),
    .rst     (rst),
    .wipe    (busy),
    .accept  (accept),
    .evt     (evt_core),
    .clr_we  (wr_isr),
    .clr_data(reg_wr_data),
    .q       (isr_q)
  );

  csirx_w1c_bank #(.W(EXT_W), .MASK(32'hFFFF_FFFF)) u_ext (
    .clk     (clk),
    .rst     (rst),
    .wipe    (busy),
    .accept  (accept),
    .evt     (evt_ext),
    .clr_we  (wr_ext),
    .clr_data(reg_wr_data[EXT_W-1:0]),
    .q       (ext_q)
  );

  assign summary = |ext_q;

  always_comb begin
    isr_view              = isr_q;
    isr_view[SUMMARY_BIT] = summary;
    stat_word             = {16'(pkt_count_i), 12'd0, spkt_full_i, spkt_ne_i,
                             lbuf_full_i, busy};
  end

  always_comb begin
    rd_mux = 32'd0;
    if (reg_rd_addr == ADDR_W'(OFS_CTRL))     rd_mux = {30'd0, ctrl_srst_q, ctrl_en_q};
    else if (reg_rd_addr == ADDR_W'(OFS_STAT)) rd_mux = stat_word;
    else if (reg_rd_addr == ADDR_W'(OFS_GIE))  rd_mux = {31'd0, gie_q};
    else if (reg_rd_addr == ADDR_W'(OFS_ISR))  rd_mux = isr_view;
    else if (reg_rd_addr == ADDR_W'(OFS_IER))  rd_mux = ier_q;
    else if (reg_rd_addr == ADDR_W'(OFS_EXT))  rd_mux = 32'(ext_q);
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rd_data <= 32'd0;
    else if (reg_rd_en) reg_rd_data <= rd_mux;
  end

  csirx_irq_gen u_irq (
    .clk    (clk),
    .rst    (rst),
    .gie    (gie_q),
    .isr    (isr_q),
    .ier    (ier_q),
    .summary(summary),
    .irq    (irq_o)
  );
endmodule

// File: rtl/csirx_regs_chk.sv
module csirx_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int EXT_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              en,
  input logic              gie,
  input logic [31:0]       isr,
  input logic [EXT_W-1:0]  ext,
  input logic [31:0]       evt,
  input logic              irq,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data
);
  import csirx_reg_pkg::*;

  logic [7:0] busy_run;
  logic       mapped;

  always_ff @(posedge clk) begin
    if (rst)                       busy_run <= 8'd0;
    else if (busy && busy_run != 8'hFF) busy_run <= busy_run + 8'd1;
    else if (!busy)                busy_run <= 8'd0;
  end

  assign mapped = (rd_addr == ADDR_W'(OFS_CTRL)) || (rd_addr == ADDR_W'(OFS_STAT)) ||
                  (rd_addr == ADDR_W'(OFS_GIE))  || (rd_addr == ADDR_W'(OFS_ISR))  ||
                  (rd_addr == ADDR_W'(OFS_IER))  || (rd_addr == ADDR_W'(OFS_EXT));

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy_run < 8'd100); // R3
  AST_BUSY_WIPES: assert property (@(posedge clk) disable iff (rst)
    busy |=> (isr == 32'd0 && ext == '0)); // R3
  AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (rst)
    (en && !busy && (evt & STORE_MASK) != 32'd0)
      |=> ((isr & $past(evt & STORE_MASK)) == $past(evt & STORE_MASK))); // R6
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq); // R8
  AST_SUMMARY_RAISES: assert property (@(posedge clk) disable iff (rst)
    (gie && ext != '0) |=> irq); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rd_data == 32'd0); // R10
endmodule

bind csi_rx_ctrl_regs csirx_regs_chk #(.ADDR_W(ADDR_W), .EXT_W(2*NUM_EXT_VC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .en     (ctrl_en_q),
  .gie    (gie_q),
  .isr    (isr_q),
  .ext    (ext_q),
  .evt    (evt_core),
  .irq    (irq_o),
  .rd_en  (reg_rd_en),
  .rd_addr(reg_rd_addr),
  .rd_data(reg_rd_data)
);

// File: tb/test_csi_rx_ctrl_regs.sv
`timescale 1ns/1ps
module test_csi_rx_ctrl_regs;
  localparam int ADDR_W = 8;
  localparam int NVC    = 12;
  localparam int EW     = 2 * NVC;
  localparam int PW     = 16;
  localparam int RCYC   = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    wr_addr = '0, rd_addr = '0;
  logic [31:0]   wr_data = '0, rd_data;
  logic [31:0]   evc = '0;
  logic [EW-1:0] evx = '0;
  logic          lbf = 1'b0, sne = 1'b0, sfl = 1'b0;
  logic [PW-1:0] pkt = '0;
  logic          irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  csi_rx_ctrl_regs #(.ADDR_W(ADDR_W), .NUM_EXT_VC(NVC), .PKT_W(PW), .RESET_CYCLES(RCYC)) i_csi_rx_ctrl_regs (
    .clk(clk), .rst(rst),
    .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .reg_rd_en(rd_en), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .evt_core(evc), .evt_ext(evx),
    .lbuf_full_i(lbf), .spkt_ne_i(sne), .spkt_full_i(sfl), .pkt_count_i(pkt),
    .irq_o(irq)
  );

  // event pattern, clear mask, expected status after both
  localparam logic [95:0] VECS [6] = '{
    {32'h8000_0001, 32'h0000_0000, 32'h8000_0001},
    {32'h0000_FFFF, 32'h0000_0000, 32'h8000_3FFF},
    {32'h007E_0000, 32'h8000_0000, 32'h007E_3FFF},
    {32'h3F81_0000, 32'h0000_3FFF, 32'h007E_0000},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_0400, 32'h0000_0000, 32'h0000_0400}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic [31:0] c, input logic [EW-1:0] x);
    @(negedge clk);
    evc = c; evx = x;
    @(negedge clk);
    evc = '0; evx = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int polls;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h24, v); check("R1 isr", v, 32'h0);
    rd(8'h28, v); check("R1 ier", v, 32'h0);
    rd(8'h20, v); check("R1 gie", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R5 events dropped while disabled
    pulse(32'h8000_0001, '0);
    rd(8'h24, v); check("R5 disabled", v, 32'h0);

    // R2 enable readback
    wr(8'h00, 32'h1);
    rd(8'h00, v); check("R2 ctrl", v, 32'h1);

    // R5/R6 table walk
    for (int i = 0; i < 6; i++) begin
      pulse(VECS[i][95:64], '0);
      if (VECS[i][63:32] != 0) wr(8'h24, VECS[i][63:32]);
      rd(8'h24, v); check("R5/R6 table", v, VECS[i][31:0]);
    end
    wr(8'h24, 32'hFFFF_FFFF);

    // R6 same-cycle event and clear: event wins
    @(negedge clk);
    evc = 32'h100; wr_en = 1'b1; wr_addr = 8'h24; wr_data = 32'h100;
    @(negedge clk);
    evc = '0; wr_en = 1'b0;
    rd(8'h24, v); check("R6 collision", v, 32'h100);
    wr(8'h24, 32'h100);
    rd(8'h24, v); check("R6 clear", v, 32'h0);

    // R7 enable masks
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, v); check("R7 ier mask", v, 32'h807E_3FFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R7 gie", v, 32'h1);

    // R8 interrupt
    idle(2); check("R8 idle low", {31'd0, irq}, 32'h0);
    pulse(32'h8000_0000, '0);
    idle(1); check("R8 raised", {31'd0, irq}, 32'h1);
    wr(8'h20, 32'h0); idle(1);
    check("R8 gie off", {31'd0, irq}, 32'h0);
    wr(8'h28, 32'h0); wr(8'h20, 32'h1); idle(1);
    check("R8 source masked", {31'd0, irq}, 32'h0);
    wr(8'h24, 32'h8000_0000);

    // R9 extended channels and summary
    pulse('0, 24'h80_0001);
    rd(8'h34, v); check("R9 ext set", v, 32'h0080_0001);
    rd(8'h24, v); check("R9 summary", v, 32'h4000_0000);
    check("R9 summary irq", {31'd0, irq}, 32'h1);
    wr(8'h24, 32'h4000_0000);
    rd(8'h24, v); check("R10 summary not writable", v, 32'h4000_0000);
    wr(8'h34, 32'h1);
    rd(8'h34, v); check("R9 partial clear", v, 32'h0080_0000);
    wr(8'h34, 32'h0080_0000);
    rd(8'h24, v); check("R9 summary gone", v, 32'h0);
    idle(1); check("R9 irq gone", {31'd0, irq}, 32'h0);

    // R4 status word
    lbf = 1'b1; sfl = 1'b1; pkt = 16'hBEEF;
    rd(8'h10, v); check("R4 status", v, 32'hBEEF_000A);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R10 status read-only", v, 32'hBEEF_000A);
    lbf = 1'b0; sfl = 1'b0; sne = 1'b1; pkt = 16'h0001;
    rd(8'h10, v); check("R4 fifo ne", v, 32'h0001_0004);
    sne = 1'b0; pkt = '0;

    // R10 unmapped
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R10 unmapped 04", v, 32'h0);
    rd(8'h30, v); check("R10 unmapped 30", v, 32'h0);

    // R3 soft reset handshake
    wr(8'h28, 32'h3);
    pulse(32'h1, 24'h1);
    wr(8'h00, 32'h3);
    idle(1);
    rd(8'h10, v); check("R3 busy seen", {31'd0, v[0]}, 32'h1);
    polls = 1;
    while (v[0] && polls < 200) begin
      rd(8'h10, v);
      polls++;
    end
    check("R3 busy within 100", {31'd0, (polls < 100)}, 32'h1);
    rd(8'h24, v); check("R3 isr wiped", v, 32'h0);
    rd(8'h34, v); check("R3 ext wiped", v, 32'h0);
    rd(8'h28, v); check("R3 ier kept", v, 32'h3);
    rd(8'h20, v); check("R3 gie kept", v, 32'h1);
    idle(20);
    rd(8'h10, v); check("R3 no rebusy", {31'd0, v[0]}, 32'h0);
    rd(8'h00, v); check("R2 req readback", v, 32'h3);
    wr(8'h00, 32'h1);
    pulse(32'h1, '0);
    rd(8'h24, v); check("R5 after reset", v, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule